// File: doc/BRIEF.md
# Paper Tape Reader IOT Controller

This block is the hardware-speed half of an emulated high-speed paper tape reader on a minicomputer's programmed-I/O bus. The CPU side puts a 6-bit device code on the select lines and fires up to three IOT strobes. When the code matches the reader's own code, the block does three things. It answers a skip test by pulling an active-low skip line while its ready flag is set. It drives the current character onto the data bus with a driver enable. It also turns a fetch strobe into an interrupt request toward a local host processor.

The host runs the slow half of the emulation: it reads tape images and feeds characters in. It uses a small write-only register interface. A write to the character register places a byte in a one-deep holding register. A write to the control register can set the ready flag, which moves any pending byte into the register the CPU reads. The same control write can also clear the sticky interrupt. Because the host may stage the next byte while the CPU still owns the current one, the reader is double-buffered. This lets it run far faster than a mechanical reader.

The IOT strobes arrive from another clock domain. Each one passes through a flip-flop synchronizer, and its rising edge is detected before it acts on the flag or the interrupt.

Top module: `ptr_iot_ctrl`

## Requirements
- R1: After a synchronous reset, skip_n is 1, bus_oe is 0, bus_data is 0, host_irq is 0 and the ready flag is clear, so a skip test does not skip.
- R2: When dev_sel differs from DEV_CODE (default octal 01), any strobe leaves skip_n at 1, bus_oe at 0 and bus_data at 0. It also does not change the flag and does not raise host_irq.
- R3: While the synchronized skip strobe (iot_skip) is high, the device code matches and the flag is set, skip_n is 0. With the flag clear it stays 1.
- R4: While the synchronized read strobe (iot_read) is high and the code matches, bus_oe is 1 and bus_data carries the presented character. At other times bus_oe is 0 and bus_data is 0. The rising edge of the strobe clears the flag.
- R5: A matching rising edge of the fetch strobe (iot_fetch) clears the flag and sets host_irq.
- R6: host_irq stays set until the host writes the control register with bit 1 set. A second fetch before then keeps it set. If a clear and a fetch land on the same clock, the fetch wins.
- R7: A host write with host_addr 0 loads host_wdata into the holding register. A write with host_addr 1 and bit 0 set sets the flag and moves a pending held byte to the presented character. If no byte is pending, the presented character is unchanged.
- R8: A byte written ahead while the CPU still reads the current one does not disturb the presented character until the next flag set.
- R9: With read and fetch strobes together, the character is driven on the bus, the flag is cleared and host_irq is set.
- R10: If a flag-set write lands on the same clock as a strobe-driven clear, the flag ends clear. The held byte stays pending and is presented by the next flag set.
- R11: Each strobe passes through SYNC_STAGES flip-flops. A strobe raised between two clock edges reaches skip_n on the SYNC_STAGES-th following edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 6 | Device code lines from the CPU |
| iot_skip | input | 1 | Asynchronous skip-test strobe (IOT 1) |
| iot_read | input | 1 | Asynchronous read-buffer strobe (IOT 2) |
| iot_fetch | input | 1 | Asynchronous fetch-character strobe (IOT 4) |
| skip_n | output | 1 | Active-low skip request |
| bus_oe | output | 1 | Data bus driver enable |
| bus_data | output | CHAR_W | Character toward the data bus, zero when not enabled |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 1 | 0 selects the character register, 1 the control register |
| host_wdata | input | CHAR_W | Host write data |
| host_irq | output | 1 | Sticky fetch request toward the host |

## Verification
The bench builds the block with DEV_CODE at octal 01, CHAR_W at 8 and SYNC_STAGES at 2. The two-stage synchronizer makes the strobe-to-output latency exactly two edges. This lets the bench place a host flag-set write on the very clock where a strobe clear takes effect and probe the R10 race directly. It also lets the bench check the edge on which skip_n first responds. The 8-bit width lets the test bytes carry distinct high and low nibbles, so a stale or swapped character from the holding stage shows up at once.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    localparam int CODE_W = 6;
    localparam int IOT_N  = 3;

    localparam int IOT_SKIP  = 0;
    localparam int IOT_READ  = 1;
    localparam int IOT_FETCH = 2;

    localparam int CTRL_SET_FLAG = 0;
    localparam int CTRL_CLR_IRQ  = 1;

    typedef enum logic {
        HREG_CHAR = 1'b0,
        HREG_CTRL = 1'b1
    } host_reg_e;

    typedef struct packed {
        logic clr_flag;
        logic fetch_req;
    } cpu_evt_t;

    typedef struct packed {
        logic set_flag;
        logic clr_irq;
        logic load_char;
    } host_cmd_t;

    function automatic logic code_hit(input logic [CODE_W-1:0] seen,
                                      input logic [CODE_W-1:0] own);
        return seen == own;
    endfunction

endpackage

// File: rtl/ptr_strobe_sync.sv
module ptr_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= raw_i;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = level_o & ~last;

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ptr_iot_decode.sv
module ptr_iot_decode
    import ptr_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_CODE = 6'o01,
    parameter int                CHAR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] dev_sel,
    input  logic [IOT_N-1:0]  level,
    input  logic [IOT_N-1:0]  rise,
    input  logic              flag,
    input  logic [CHAR_W-1:0] pres_char,
    output logic              skip_n,
    output logic              bus_oe,
    output logic [CHAR_W-1:0] bus_data,
    output cpu_evt_t          evt
);
    logic             hit;
    logic [IOT_N-1:0] g_level;
    logic [IOT_N-1:0] g_rise;

    assign hit = code_hit(dev_sel, DEV_CODE);

    genvar i;
    generate
        for (i = 0; i < IOT_N; i++) begin : g_gate
            assign g_level[i] = level[i] & hit;
            assign g_rise[i]  = rise[i] & hit;
        end
    endgenerate

    always_comb begin
        skip_n        = ~(g_level[IOT_SKIP] & flag);
        bus_oe        = g_level[IOT_READ];
        bus_data      = g_level[IOT_READ] ? pres_char : '0;
        evt.clr_flag  = g_rise[IOT_READ] | g_rise[IOT_FETCH];
        evt.fetch_req = g_rise[IOT_FETCH];
    end

    assert_foreign_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (skip_n && !bus_oe && bus_data == '0 && evt == '0));

    assert_skip_only_on_flag_R3: assert property (@(posedge clk) disable iff (rst)
        !skip_n |-> (flag && level[IOT_SKIP]));

endmodule

// File: rtl/ptr_reader_state.sv
module ptr_reader_state
    import ptr_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cpu_evt_t          evt,
    input  host_cmd_t         cmd,
    input  logic [CHAR_W-1:0] wdata,
    output logic              flag,
    output logic [CHAR_W-1:0] pres_char,
    output logic              irq
);
    logic [CHAR_W-1:0] hold_char;
    logic              hold_vld;
    logic              take;

    assign take = cmd.set_flag & ~evt.clr_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag      <= 1'b0;
            pres_char <= '0;
            hold_char <= '0;
            hold_vld  <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (evt.clr_flag)  flag <= 1'b0;
            else if (take)     flag <= 1'b1;

            if (cmd.load_char) begin
                hold_char <= wdata;
                hold_vld  <= 1'b1;
            end else if (take && hold_vld) begin
                pres_char <= hold_char;
                hold_vld  <= 1'b0;
            end

            if (evt.fetch_req)    irq <= 1'b1;
            else if (cmd.clr_irq) irq <= 1'b0;
        end
    end

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        evt.clr_flag |=> !flag);

    assert_fetch_raises_R5: assert property (@(posedge clk) disable iff (rst)
        evt.fetch_req |=> irq);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && !cmd.clr_irq) |=> irq);

    assert_set_moves_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (take && hold_vld) |=> (flag && pres_char == $past(hold_char)));

    assert_char_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(pres_char));

endmodule

// File: rtl/ptr_iot_ctrl.sv
module ptr_iot_ctrl
    import ptr_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_CODE    = 6'o01,
    parameter int                CHAR_W      = 8,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] dev_sel,
    input  logic              iot_skip,
    input  logic              iot_read,
    input  logic              iot_fetch,
    output logic              skip_n,
    output logic              bus_oe,
    output logic [CHAR_W-1:0] bus_data,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [CHAR_W-1:0] host_wdata,
    output logic              host_irq
);
    logic [IOT_N-1:0]  raw;
    logic [IOT_N-1:0]  level;
    logic [IOT_N-1:0]  rise;
    cpu_evt_t          evt;
    host_cmd_t         cmd;
    logic              flag;
    logic [CHAR_W-1:0] pres_char;

    assign raw[IOT_SKIP]  = iot_skip;
    assign raw[IOT_READ]  = iot_read;
    assign raw[IOT_FETCH] = iot_fetch;

    genvar k;
    generate
        for (k = 0; k < IOT_N; k++) begin : g_sync
            ptr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst     (rst),
                .raw_i   (raw[k]),
                .level_o (level[k]),
                .rise_o  (rise[k])
            );
        end
    endgenerate

    always_comb begin
        cmd.load_char = host_we && (host_reg_e'(host_addr) == HREG_CHAR);
        cmd.set_flag  = host_we && (host_reg_e'(host_addr) == HREG_CTRL)
                        && host_wdata[CTRL_SET_FLAG];
        cmd.clr_irq   = host_we && (host_reg_e'(host_addr) == HREG_CTRL)
                        && host_wdata[CTRL_CLR_IRQ];
    end

    ptr_iot_decode #(.DEV_CODE(DEV_CODE), .CHAR_W(CHAR_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .dev_sel   (dev_sel),
        .level     (level),
        .rise      (rise),
        .flag      (flag),
        .pres_char (pres_char),
        .skip_n    (skip_n),
        .bus_oe    (bus_oe),
        .bus_data  (bus_data),
        .evt       (evt)
    );

    ptr_reader_state #(.CHAR_W(CHAR_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cmd       (cmd),
        .wdata     (host_wdata),
        .flag      (flag),
        .pres_char (pres_char),
        .irq       (host_irq)
    );

    assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_data == '0));

endmodule

// File: tb/ptr_iot_ctrl_bench.sv
module ptr_iot_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] dev_sel;
    logic       iot_skip, iot_read, iot_fetch;
    logic       skip_n, bus_oe, host_irq;
    logic [7:0] bus_data;
    logic       host_we, host_addr;
    logic [7:0] host_wdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ptr_iot_ctrl u_ptr_iot_ctrl (
        .clk(clk), .rst(rst), .dev_sel(dev_sel),
        .iot_skip(iot_skip), .iot_read(iot_read), .iot_fetch(iot_fetch),
        .skip_n(skip_n), .bus_oe(bus_oe), .bus_data(bus_data),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_wdata = '0;
    endtask

    task automatic iot(input logic [5:0] code, input logic s, input logic r, input logic f,
                       output logic sk, output logic oe, output logic [7:0] dat);
        @(negedge clk);
        dev_sel = code;
        repeat (2) @(negedge clk);
        iot_skip = s; iot_read = r; iot_fetch = f;
        repeat (4) @(negedge clk);
        sk = skip_n; oe = bus_oe; dat = bus_data;
        iot_skip = 1'b0; iot_read = 1'b0; iot_fetch = 1'b0;
        repeat (4) @(negedge clk);
        dev_sel = 6'o00;
        @(negedge clk);
    endtask

    task automatic flag_probe(input string req, input logic exp_set);
        logic sk, oe; logic [7:0] d;
        iot(6'o01, 1'b1, 1'b0, 1'b0, sk, oe, d);
        chk(req, {7'b0, sk}, {7'b0, ~exp_set});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 skip_n", {7'b0, skip_n}, 8'h01);
        chk("R1 bus_oe", {7'b0, bus_oe}, 8'h00);
        chk("R1 bus_data", bus_data, 8'h00);
        chk("R1 host_irq", {7'b0, host_irq}, 8'h00);
        flag_probe("R1 flag clear", 1'b0);
    endtask

    task automatic t_load_read;
        logic sk, oe; logic [7:0] d;
        host_wr(1'b0, 8'hA5);
        host_wr(1'b1, 8'h01);
        flag_probe("R7 flag set by host", 1'b1);
        chk("R4 idle bus_oe", {7'b0, bus_oe}, 8'h00);
        iot(6'o01, 1'b0, 1'b1, 1'b0, sk, oe, d);
        chk("R4 read oe", {7'b0, oe}, 8'h01);
        chk("R4 read data", d, 8'hA5);
        chk("R4 bus released", bus_data, 8'h00);
        flag_probe("R4 flag cleared by read", 1'b0);
    endtask

    task automatic t_foreign;
        logic sk, oe; logic [7:0] d;
        host_wr(1'b1, 8'h01);
        iot(6'o02, 1'b1, 1'b1, 1'b1, sk, oe, d);
        chk("R2 skip_n", {7'b0, sk}, 8'h01);
        chk("R2 bus_oe", {7'b0, oe}, 8'h00);
        chk("R2 bus_data", d, 8'h00);
        chk("R2 host_irq", {7'b0, host_irq}, 8'h00);
        flag_probe("R2 flag kept", 1'b1);
        iot(6'o41, 1'b0, 1'b0, 1'b1, sk, oe, d);
        chk("R2 upper-bit code irq", {7'b0, host_irq}, 8'h00);
    endtask

    task automatic t_fetch;
        logic sk, oe; logic [7:0] d;
        iot(6'o01, 1'b0, 1'b0, 1'b1, sk, oe, d);
        chk("R5 irq set", {7'b0, host_irq}, 8'h01);
        chk("R5 fetch drives no bus", {7'b0, oe}, 8'h00);
        flag_probe("R5 flag cleared by fetch", 1'b0);
        iot(6'o01, 1'b0, 1'b0, 1'b1, sk, oe, d);
        chk("R6 irq still set", {7'b0, host_irq}, 8'h01);
        host_wr(1'b1, 8'h00);
        chk("R6 irq kept without clear bit", {7'b0, host_irq}, 8'h01);
        host_wr(1'b1, 8'h02);
        chk("R6 irq cleared", {7'b0, host_irq}, 8'h00);
    endtask

    task automatic t_double;
        logic sk, oe; logic [7:0] d;
        host_wr(1'b0, 8'h1E);
        host_wr(1'b1, 8'h01);
        host_wr(1'b0, 8'h2D);
        iot(6'o01, 1'b0, 1'b1, 1'b0, sk, oe, d);
        chk("R8 first byte intact", d, 8'h1E);
        host_wr(1'b1, 8'h01);
        iot(6'o01, 1'b0, 1'b1, 1'b0, sk, oe, d);
        chk("R8 staged byte presented", d, 8'h2D);
        host_wr(1'b1, 8'h01);
        iot(6'o01, 1'b0, 1'b1, 1'b0, sk, oe, d);
        chk("R7 set without hold keeps byte", d, 8'h2D);
    endtask

    task automatic t_combined;
        logic sk, oe; logic [7:0] d;
        host_wr(1'b0, 8'h3C);
        host_wr(1'b1, 8'h01);
        iot(6'o01, 1'b0, 1'b1, 1'b1, sk, oe, d);
        chk("R9 data", d, 8'h3C);
        chk("R9 oe", {7'b0, oe}, 8'h01);
        chk("R9 irq", {7'b0, host_irq}, 8'h01);
        flag_probe("R9 flag cleared", 1'b0);
        host_wr(1'b1, 8'h02);
    endtask

    task automatic t_race;
        logic sk, oe; logic [7:0] d;
        host_wr(1'b0, 8'h5A);
        @(negedge clk);
        dev_sel = 6'o01;
        repeat (2) @(negedge clk);
        iot_fetch = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b1; host_addr = 1'b1; host_wdata = 8'h01;
        @(negedge clk);
        host_we = 1'b0; host_wdata = '0;
        repeat (2) @(negedge clk);
        iot_fetch = 1'b0;
        repeat (4) @(negedge clk);
        dev_sel = 6'o00;
        chk("R10 irq from racing fetch", {7'b0, host_irq}, 8'h01);
        flag_probe("R10 clear wins", 1'b0);
        host_wr(1'b1, 8'h03);
        iot(6'o01, 1'b0, 1'b1, 1'b0, sk, oe, d);
        chk("R10 held byte presented later", d, 8'h5A);
    endtask

    task automatic t_latency;
        host_wr(1'b1, 8'h01);
        @(negedge clk);
        dev_sel = 6'o01;
        repeat (2) @(negedge clk);
        iot_skip = 1'b1;
        @(negedge clk);
        chk("R11 no skip after one edge", {7'b0, skip_n}, 8'h01);
        @(negedge clk);
        chk("R3 skip after two edges R11", {7'b0, skip_n}, 8'h00);
        iot_skip = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 skip released", {7'b0, skip_n}, 8'h01);
        dev_sel = 6'o00;
    endtask

    initial begin
        rst = 1'b1; dev_sel = '0;
        iot_skip = 0; iot_read = 0; iot_fetch = 0;
        host_we = 0; host_addr = 0; host_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_read();
        t_foreign();
        t_fetch();
        t_double();
        t_combined();
        t_race();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule